// File: doc/BRIEF.md
# Pulse-Width Symbol Demodulator

This block turns a stream of per-carrier-cycle amplitude samples into pulse-width coded symbols. Each strobe on `cyc_stb_i` delivers two signed amplitudes for one carrier cycle. The raw amplitude is the instantaneous cycle amplitude. The integrated amplitude is averaged over many bauds and is stable enough for framing. A baud lasts ten cycles. The symbol it carries is the number of leading cycles that stay high.

The integrated decisions locate the baud boundary. They are compared with the midpoint of the previous baud's peak and floor, and a fixed high/low signature is searched for in their history. The raw decisions are made against a slice level that is rebuilt at every boundary. At each boundary the last eight raw decisions are classified as a zero, a one, or a position marker. Unrecognised run shapes raise a decode error. A boundary signature that arrives off the expected count raises a sync error and realigns the count.

Top module: `pw_symbol_demod`

## Requirements
- R1: An internal cycle phase advances by one on every strobe, modulo 10, and is 0 after reset. A strobe that leaves the phase at 0 is a baud boundary. `sym_valid_o` is high for exactly the one clock that follows a boundary strobe and is low at all other times.
- R2: Each strobe's integrated decision is high when `int_amp_i` is at least floor((peak + noise) / 2). Peak and noise are the values latched at the last boundary, and both are 0 after reset.
- R3: The integrated decisions enter a 32-bit history, newest in bit 0. A strobe whose updated history ANDed with 0x303C0F03 equals 0x300C0300 forces the phase to 0. If the phase would otherwise not have been 0, `sync_err_o` is high for the one clock after that strobe. It is low at all other times.
- R4: Each strobe's raw decision is high when `raw_amp_i` is at least the current slice level. The slice level is 0 after reset. At phase 1 the tracked maximum is loaded with the raw amplitude, and at phase 2 it takes the larger of the two values. At phase 9 the tracked minimum is loaded. At phase 0 the minimum takes the smaller value, and the slice becomes floor((max + min) / 2). Both trackers then return to their reset values: the most negative value for the maximum and the most positive value for the minimum.
- R5: At a boundary, when the last eight raw decisions (newest in bit 0) equal 0x00 or 0x80, `sym_o` is 0.
- R6: At a boundary, when the last eight raw decisions equal 0xC0, 0xE0 or 0xF0, `sym_o` is 1.
- R7: At a boundary, when the last eight raw decisions equal 0xF8, 0xFC or 0xFE, `sym_o` is 2 (position marker). The value 3 never appears on `sym_o`.
- R8: Any other eight-bit pattern at a boundary gives `sym_o` = 0, with `dec_err_o` high alongside `sym_valid_o`. `dec_err_o` is never high without `sym_valid_o`.
- R9: Between boundaries, the largest and smallest integrated amplitudes are tracked. At a boundary strobe, the values that include that strobe's amplitude are latched as the new peak and noise.
- R10: While `rst_ni` is low, all outputs are 0.
- R11: A clock without a strobe changes no internal state. All outputs are 0 in the clock that follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cyc_stb_i | input | 1 | One carrier cycle's amplitudes are present |
| raw_amp_i | input | AMP_W | Signed raw cycle amplitude |
| int_amp_i | input | AMP_W | Signed integrated cycle amplitude |
| sym_o | output | 2 | Symbol: 0 zero, 1 one, 2 position marker |
| sym_valid_o | output | 1 | One-clock strobe for `sym_o` |
| sync_err_o | output | 1 | Boundary signature seen off the expected count |
| dec_err_o | output | 1 | Unrecognised pulse shape in the emitted symbol |

## Verification
A realignment and a symbol decision can happen on the same strobe. A signature match forces the phase to 0, and that strobe is then a boundary. It must emit a symbol, rebuild the slice and latch peak and noise, all while reporting a sync error. The bench provokes this in two ways: by inserting extra cycles before the first baud and by slipping a baud by one cycle mid-stream. A behavioural model runs alongside the design and is compared with its outputs on every clock. The model must show the sync error and the symbol emitted from the truncated baud's raw history on the same clock. The bench also shifts the amplitude levels, so that the decisions made before the slice and threshold adapt are judged as well.

// File: rtl/pw_demod_pkg.sv
package pw_demod_pkg;

  typedef enum logic [1:0] {
    SYM_ZERO = 2'd0,
    SYM_ONE  = 2'd1,
    SYM_MARK = 2'd2
  } sym_e;

  typedef struct packed {
    logic bad;
    sym_e sym;
  } sym_dec_t;

  // Run-length classifier over the last eight raw decisions.
  function automatic sym_dec_t classify(input logic [7:0] runs);
    sym_dec_t d;
    d.bad = 1'b0;
    unique case (runs)
      8'h00, 8'h80:        d.sym = SYM_ZERO;
      8'hC0, 8'hE0, 8'hF0: d.sym = SYM_ONE;
      8'hF8, 8'hFC, 8'hFE: d.sym = SYM_MARK;
      default: begin
        d.sym = SYM_ZERO;
        d.bad = 1'b1;
      end
    endcase
    return d;
  endfunction

endpackage

// File: rtl/baud_align.sv
module baud_align #(
  parameter int unsigned HIST_W   = 32,
  parameter int unsigned BAUD_LEN = 10,
  parameter logic [HIST_W-1:0] SIG_MASK = 32'h303C0F03,
  parameter logic [HIST_W-1:0] SIG_PAT  = 32'h300C0300,
  localparam int unsigned PH_W = $clog2(BAUD_LEN)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            stb_i,
  input  logic            bit_i,
  output logic [PH_W-1:0] phase_nxt_o,
  output logic            slip_o
);

  logic [HIST_W-2:0] hist_q;
  logic [HIST_W-1:0] hist_nxt;
  logic [PH_W-1:0]   phase_q, phase_inc;
  logic              hit;

  assign hist_nxt  = {hist_q, bit_i};
  assign phase_inc = (phase_q == PH_W'(BAUD_LEN - 1)) ? '0 : phase_q + 1'b1;
  assign hit       = (hist_nxt & SIG_MASK) == SIG_PAT;
  assign phase_nxt_o = hit ? '0 : phase_inc;
  assign slip_o    = stb_i && hit && (phase_inc != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q  <= '0;
      phase_q <= '0;
    end else if (stb_i) begin
      hist_q  <= hist_nxt[HIST_W-2:0];
      phase_q <= phase_nxt_o;
    end
  end

  assert_phase_range_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_q < PH_W'(BAUD_LEN));

  assert_idle_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stb_i |=> $stable(phase_q) && $stable(hist_q));

endmodule

// File: rtl/level_track.sv
module level_track #(
  parameter int unsigned AMP_W = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    stb_i,
  input  logic                    bound_i,
  input  logic signed [AMP_W-1:0] amp_i,
  output logic signed [AMP_W-1:0] thr_o
);

  localparam logic signed [AMP_W-1:0] AMP_MAX = {1'b0, {(AMP_W-1){1'b1}}};
  localparam logic signed [AMP_W-1:0] AMP_MIN = {1'b1, {(AMP_W-1){1'b0}}};

  logic signed [AMP_W-1:0] peak_q, noise_q, tmax_q, tmin_q, tmax_u, tmin_u;
  logic signed [AMP_W:0]   sum;

  assign sum    = $signed({peak_q[AMP_W-1], peak_q}) + $signed({noise_q[AMP_W-1], noise_q});
  assign thr_o  = sum[AMP_W:1];
  assign tmax_u = (amp_i > tmax_q) ? amp_i : tmax_q;
  assign tmin_u = (amp_i < tmin_q) ? amp_i : tmin_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      peak_q  <= '0;
      noise_q <= '0;
      tmax_q  <= AMP_MIN;
      tmin_q  <= AMP_MAX;
    end else if (stb_i) begin
      if (bound_i) begin
        peak_q  <= tmax_u;
        noise_q <= tmin_u;
        tmax_q  <= AMP_MIN;
        tmin_q  <= AMP_MAX;
      end else begin
        tmax_q  <= tmax_u;
        tmin_q  <= tmin_u;
      end
    end
  end

  assert_latch_order_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_i && bound_i |=> peak_q >= noise_q);

endmodule

// File: rtl/slice_track.sv
module slice_track #(
  parameter int unsigned AMP_W    = 16,
  parameter int unsigned BAUD_LEN = 10,
  localparam int unsigned PH_W = $clog2(BAUD_LEN)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    stb_i,
  input  logic [PH_W-1:0]         phase_i,
  input  logic signed [AMP_W-1:0] amp_i,
  output logic [7:0]              runs_o
);

  localparam logic signed [AMP_W-1:0] AMP_MAX = {1'b0, {(AMP_W-1){1'b1}}};
  localparam logic signed [AMP_W-1:0] AMP_MIN = {1'b1, {(AMP_W-1){1'b0}}};

  logic [6:0]              runs_q;
  logic signed [AMP_W-1:0] slice_q, emax_q, emin_q, emin_u;
  logic signed [AMP_W:0]   sum;

  assign runs_o = {runs_q, amp_i >= slice_q};
  assign emin_u = (amp_i < emin_q) ? amp_i : emin_q;
  assign sum    = $signed({emax_q[AMP_W-1], emax_q}) + $signed({emin_u[AMP_W-1], emin_u});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      runs_q  <= '0;
      slice_q <= '0;
      emax_q  <= AMP_MIN;
      emin_q  <= AMP_MAX;
    end else if (stb_i) begin
      runs_q <= runs_o[6:0];
      if (phase_i == '0) begin
        slice_q <= sum[AMP_W:1];
        emax_q  <= AMP_MIN;
        emin_q  <= AMP_MAX;
      end else if (phase_i == PH_W'(1)) begin
        emax_q <= amp_i;
      end else if (phase_i == PH_W'(2)) begin
        if (amp_i > emax_q) emax_q <= amp_i;
      end else if (phase_i == PH_W'(BAUD_LEN - 1)) begin
        emin_q <= amp_i;
      end
    end
  end

  assert_slice_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stb_i |=> $stable(slice_q));

  assert_slice_only_at_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_i && phase_i != '0 |=> $stable(slice_q));

endmodule

// File: rtl/pw_symbol_demod.sv
module pw_symbol_demod
  import pw_demod_pkg::*;
#(
  parameter int unsigned AMP_W    = 16,
  parameter int unsigned BAUD_LEN = 10,
  parameter int unsigned HIST_W   = 32,
  parameter logic [HIST_W-1:0] SIG_MASK = 32'h303C0F03,
  parameter logic [HIST_W-1:0] SIG_PAT  = 32'h300C0300
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    cyc_stb_i,
  input  logic signed [AMP_W-1:0] raw_amp_i,
  input  logic signed [AMP_W-1:0] int_amp_i,
  output logic [1:0]              sym_o,
  output logic                    sym_valid_o,
  output logic                    sync_err_o,
  output logic                    dec_err_o
);

  localparam int unsigned PH_W = $clog2(BAUD_LEN);

  logic signed [AMP_W-1:0] thr;
  logic [PH_W-1:0]         phase_nxt;
  logic                    slip, bound;
  logic [7:0]              runs;
  sym_dec_t                dec;

  assign bound = (phase_nxt == '0);
  assign dec   = classify(runs);

  level_track #(.AMP_W(AMP_W)) u_level (
    .clk_i, .rst_ni, .stb_i(cyc_stb_i), .bound_i(bound), .amp_i(int_amp_i), .thr_o(thr)
  );

  baud_align #(.HIST_W(HIST_W), .BAUD_LEN(BAUD_LEN), .SIG_MASK(SIG_MASK), .SIG_PAT(SIG_PAT)) u_align (
    .clk_i, .rst_ni, .stb_i(cyc_stb_i), .bit_i(int_amp_i >= thr),
    .phase_nxt_o(phase_nxt), .slip_o(slip)
  );

  slice_track #(.AMP_W(AMP_W), .BAUD_LEN(BAUD_LEN)) u_slice (
    .clk_i, .rst_ni, .stb_i(cyc_stb_i), .phase_i(phase_nxt), .amp_i(raw_amp_i), .runs_o(runs)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sym_o       <= '0;
      sym_valid_o <= 1'b0;
      sync_err_o  <= 1'b0;
      dec_err_o   <= 1'b0;
    end else begin
      sym_valid_o <= cyc_stb_i && bound;
      sync_err_o  <= slip;
      dec_err_o   <= cyc_stb_i && bound && dec.bad;
      sym_o       <= (cyc_stb_i && bound) ? dec.sym : SYM_ZERO;
    end
  end

  assert_code_legal_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sym_valid_o |-> sym_o != 2'd3);

  assert_err_with_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_err_o |-> sym_valid_o && sym_o == 2'd0);

  assert_valid_needs_stb_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sym_valid_o |-> $past(cyc_stb_i));

  assert_slip_is_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_err_o |-> sym_valid_o);

endmodule

// File: tb/sim_pw_symbol_demod.sv
module sim_pw_symbol_demod;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_ni = 0, stb = 0;
  logic signed [15:0] raw = 0, iamp = 0;
  logic [1:0] sym;
  logic vld, serr, derr;

  always #(CLK_PERIOD/2) clk = ~clk;

  pw_symbol_demod u0 (
    .clk_i(clk), .rst_ni(rst_ni), .cyc_stb_i(stb), .raw_amp_i(raw), .int_amp_i(iamp),
    .sym_o(sym), .sym_valid_o(vld), .sync_err_o(serr), .dec_err_o(derr)
  );

  int checks = 0, fails = 0, n_serr = 0, n_derr = 0;
  bit done = 0;
  string ph_tag = "R1";

  // behavioural model state
  int m_ph = 0, m_slice = 0, m_emax = -32768, m_emin = 32767;
  int m_peak = 0, m_noise = 0, m_tmax = -32768, m_tmin = 32767;
  logic [31:0] m_hist = 0;
  logic [7:0]  m_raw = 0;
  int e_vld = 0, e_sym = 0, e_derr = 0, e_serr = 0, prev_stb = 0;
  int hi_r = 800, lo_r = -800, hi_i = 1000, lo_i = -1000;

  task automatic chk(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s [%s] got %0d expected %0d at %0t", req, ph_tag, got, exp, $time);
    end
  endtask

  task automatic model(bit s, int r, int iv);
    int thr, nph, lo;
    e_vld = 0; e_sym = 0; e_derr = 0; e_serr = 0;
    if (!s) return;
    thr = (m_peak + m_noise) >>> 1;
    m_hist = {m_hist[30:0], iv >= thr};
    nph = (m_ph + 1) % 10;
    if ((m_hist & 32'h303C0F03) == 32'h300C0300) begin
      if (nph != 0) e_serr = 1;
      nph = 0;
    end
    m_ph = nph;
    m_raw = {m_raw[6:0], r >= m_slice};
    if (m_ph == 0) begin
      m_peak = (iv > m_tmax) ? iv : m_tmax;
      m_noise = (iv < m_tmin) ? iv : m_tmin;
      m_tmax = -32768; m_tmin = 32767;
    end else begin
      if (iv > m_tmax) m_tmax = iv;
      if (iv < m_tmin) m_tmin = iv;
    end
    case (m_ph)
      0: begin
        lo = (r < m_emin) ? r : m_emin;
        m_slice = (m_emax + lo) >>> 1;
        m_emax = -32768; m_emin = 32767;
      end
      1: m_emax = r;
      2: if (r > m_emax) m_emax = r;
      9: m_emin = r;
      default: ;
    endcase
    if (m_ph == 0) begin
      e_vld = 1;
      case (m_raw)
        8'h00, 8'h80: e_sym = 0;
        8'hC0, 8'hE0, 8'hF0: e_sym = 1;
        8'hF8, 8'hFC, 8'hFE: e_sym = 2;
        default: begin e_sym = 0; e_derr = 1; end
      endcase
    end
  endtask

  // compare last step, then drive and predict the next
  task automatic cyc(bit s, int r, int iv);
    string t;
    @(negedge clk);
    t = prev_stb ? "R1" : "R11";
    chk({t, " valid"}, vld, e_vld);
    chk(prev_stb ? "R3 sync_err" : "R11 sync_err", serr, e_serr);
    if (e_vld) begin
      t = e_derr ? "R8" : (e_sym == 0 ? "R5" : (e_sym == 1 ? "R6" : "R7"));
      chk({t, " symbol"}, sym, e_sym);
      chk("R8 dec_err", derr, e_derr);
    end else begin
      chk("R11 symbol idle", sym, 0);
      chk("R8 dec_err idle", derr, 0);
    end
    if (e_serr) n_serr++;
    if (e_derr) n_derr++;
    stb = s; raw = 16'(r); iamp = 16'(iv);
    model(s, r, iv);
    prev_stb = s;
  endtask

  task automatic idle();
    cyc(0, $urandom_range(0, 4000) - 2000, $urandom_range(0, 4000) - 2000);
  endtask

  // one baud: c0,c1 high; code bit7..bit0 maps to cycles c2..c9
  task automatic baud(logic [7:0] code, bit gaps);
    for (int c = 0; c < 10; c++) begin
      bit rb = (c < 2) ? 1'b1 : code[9 - c];
      int iv = (c < 2) ? hi_i : lo_i;
      cyc(1, rb ? hi_r - c : lo_r + c, iv);
      if (gaps && (c % 3 == 1)) idle();
    end
  endtask

  initial begin
    logic [7:0] codes[11] = '{8'h00, 8'h80, 8'hC0, 8'hE0, 8'hF0, 8'hF8, 8'hFC, 8'hFE, 8'hFF, 8'hA5, 8'h81};
    repeat (3) @(negedge clk);
    ph_tag = "R10";
    chk("R10 reset valid", vld, 0);
    chk("R10 reset sync", serr, 0);
    chk("R10 reset sym", sym, 0);
    chk("R10 reset dec", derr, 0);
    rst_ni = 1;
    // misaligned start: first signature match falls off phase 0 (R3)
    ph_tag = "R3";
    repeat (3) cyc(1, lo_r, lo_i);
    ph_tag = "R5 R6 R7 R8";
    for (int k = 0; k < 2; k++)
      foreach (codes[i]) baud(codes[i], k == 1);
    // level shift: slice and threshold adapt at boundaries (R4, R2, R9)
    ph_tag = "R4 R2 R9";
    hi_r = 3000; lo_r = 2000; hi_i = 5000; lo_i = 3000;
    baud(8'hC0, 0); baud(8'hF8, 0); baud(8'h00, 0); baud(8'hE0, 1);
    hi_r = -500; lo_r = -1500; hi_i = -200; lo_i = -900;
    baud(8'hFC, 0); baud(8'h80, 0); baud(8'hF0, 0);
    // slipped baud: realign coincides with symbol decode (R3)
    ph_tag = "R3 slip";
    cyc(1, lo_r, lo_i);
    baud(8'hF0, 0); baud(8'hF8, 0); baud(8'h80, 0); baud(8'hC0, 0);
    ph_tag = "R11";
    repeat (5) idle();
    cyc(0, 0, 0);
    chk("R3 sync errors seen", int'(n_serr >= 2), 1);
    chk("R8 decode errors seen", int'(n_derr >= 2), 1);
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog R1 got 0 expected 1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule